// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Two-Entry Holding Queue

This block turns an asynchronous serial line into characters for a host. The line idles high. Each character opens with a low start bit, carries 8 or 9 data bits with the least significant bit first, and closes with a high stop bit. An oversampling tick comes from a baud generator outside the block, at sixteen ticks per bit. The receiver uses it to find the middle of each bit, reject short low glitches and shift the data into a shift register. Each finished character moves in parallel into a holding queue of two entries. The host reads the queue one character at a time.

Every queue entry stores its own framing-error flag and ninth bit, so the status outputs always describe the character at the head of the queue. When a character completes while both entries are full, a sticky overrun flag is set. Reception then stops until the host drops the receive enable. An optional address filter, used only in 9-bit mode, stores only the characters whose ninth bit is 1. Dropping the port enable clears the whole receiver.

Top module: `serial_rx_unit`

## Requirements
- R1: A character is a low start bit, then 8 data bits (or 9 when `nine_bit` is 1) sent least significant bit first, then a stop bit. Each bit lasts 16 `os_tick` pulses and is sampled near its middle. Data bit k of a character appears on `rd_data[k]`.
- R2: In 9-bit mode the ninth received bit appears on `rd_bit9` together with its character. In 8-bit mode `rd_bit9` is 0.
- R3: The queue holds up to two characters and gives them out in arrival order. A one-cycle `rd_en` pulse removes the head. A read while the queue is empty has no effect. While the queue is empty, `rd_data`, `rd_bit9` and `rd_ferr` are 0.
- R4: If a character completes while two characters are held and no read happens in that cycle, `overrun` goes to 1 and that character is lost. While `overrun` is 1, no later character is stored. `overrun` returns to 0 only when `rx_en` or `port_en` is 0.
- R5: If the stop bit is sampled low, the character is still stored and `rd_ferr` is 1 while that character is at the head. After such a character, a new start is recognised only on a fresh high-to-low transition of the line.
- R6: `data_avail` is 1 exactly when the queue holds at least one character.
- R7: `rx_idle` is 1 when no character is being received. It is 0 from the detection of a start bit until the stop bit has been sampled.
- R8: When `addr_filt_en` and `nine_bit` are both 1, a character whose ninth bit is 0 is discarded. It changes neither the queue nor `overrun`. When `addr_filt_en` is 0, the ninth bit is stored as ordinary data.
- R9: A low pulse that is no longer low at the middle of the start bit is ignored. It stores nothing, and the receiver returns to idle.
- R10: While `port_en` is 0, the queue is emptied and `overrun` is cleared. Any character being received is abandoned.
- R11: While `rx_en` is 0, no character is received and none is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_en | input | 1 | Serial port enable; 0 clears the whole receiver |
| rx_en | input | 1 | Receive enable; 0 stops reception and clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| addr_filt_en | input | 1 | Keep only characters whose ninth bit is 1 (9-bit mode only) |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Serial input line, idles high |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Head character data bits |
| rd_bit9 | output | 1 | Head character ninth bit |
| rd_ferr | output | 1 | Head character framing error |
| data_avail | output | 1 | Queue is not empty |
| overrun | output | 1 | Sticky overrun flag |
| rx_idle | output | 1 | No reception in progress |

## Verification
The bench targets the third character arriving with both entries full. A design that overwrites the oldest entry, or keeps receiving after the overrun, would show the wrong head or raise `data_avail` after a later character. A character with a low stop bit is followed at once by a good one. This catches a framing flag that is not stored per entry, and a receiver that takes the low stop bit as a new start. The bench also sends short low glitches, characters with a zero ninth bit while the filter is on, reads of an empty queue, and a port disable with the queue full. These expose, in turn, a receiver that never re-checks the start bit, a filter that still raises `overrun`, a read pointer that moves past the write pointer, and flags that survive the disable.

// File: rtl/srx_pkg.sv
package srx_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              bit9;
        logic              ferr;
    } srx_char_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } srx_state_e;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic rx_i,
    output logic rx_o,
    output logic fall_o
);
    localparam int SW = STAGES + 1;

    logic [SW-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[SW-2:0], rx_i};
        if (clr_i) begin
            sh_d = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign rx_o   = sh_q[STAGES-1];
    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/srx_deframer.sv
module srx_deframer
    import srx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      hold_i,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic      fall_i,
    input  logic      nine_bit_i,
    output logic      idle_o,
    output logic      done_o,
    output srx_char_t char_o
);
    localparam int CW   = $clog2(OSR);
    localparam int MID  = OSR / 2 - 1;
    localparam int LAST = OSR - 1;
    localparam int SRW  = CHAR_W + 1;

    typedef struct packed {
        srx_state_e     st;
        logic [CW-1:0]  cnt;
        logic [3:0]     bidx;
        logic [SRW-1:0] sr;
    } dfr_t;

    dfr_t d, q;
    logic mid_hit, last_hit, last_bit;

    assign mid_hit  = tick_i && (q.cnt == CW'(MID));
    assign last_hit = tick_i && (q.cnt == CW'(LAST));
    assign last_bit = (q.bidx == (nine_bit_i ? 4'd8 : 4'd7));

    always_comb begin
        d = q;
        if (clr_i || hold_i) begin
            d.st  = ST_IDLE;
            d.cnt = '0;
        end else begin
            case (q.st)
                ST_IDLE: begin
                    if (fall_i) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    if (mid_hit) begin
                        d.cnt  = '0;
                        d.bidx = '0;
                        d.st   = rx_i ? ST_IDLE : ST_DATA;
                    end else if (tick_i) begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                ST_DATA: begin
                    if (last_hit) begin
                        d.sr  = {rx_i, q.sr[SRW-1:1]};
                        d.cnt = '0;
                        if (last_bit) begin
                            d.st = ST_STOP;
                        end else begin
                            d.bidx = q.bidx + 4'd1;
                        end
                    end else if (tick_i) begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
                default: begin
                    if (last_hit) begin
                        d.st  = ST_IDLE;
                        d.cnt = '0;
                    end else if (tick_i) begin
                        d.cnt = q.cnt + CW'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, bidx: '0, sr: '0};
        end else begin
            q <= d;
        end
    end

    assign idle_o      = (q.st == ST_IDLE);
    assign done_o      = (q.st == ST_STOP) && last_hit && !clr_i && !hold_i;
    assign char_o.data = nine_bit_i ? q.sr[CHAR_W-1:0] : q.sr[SRW-1:1];
    assign char_o.bit9 = nine_bit_i & q.sr[SRW-1];
    assign char_o.ferr = ~rx_i;

    // R11
    hold_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (q.st == ST_IDLE));

    // R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> idle_o);
endmodule

// File: rtl/srx_fifo.sv
module srx_fifo
    import srx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clr_i,
    input  logic      push_i,
    input  srx_char_t wdata_i,
    input  logic      pop_i,
    output srx_char_t head_o,
    output logic      full_o,
    output logic      empty_o
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    typedef struct packed {
        srx_char_t [DEPTH-1:0] mem;
        logic [PW-1:0]         rd;
        logic [PW-1:0]         wr;
        logic [CNTW-1:0]       cnt;
    } fifo_t;

    fifo_t d, q;
    logic  pop_ok, push_ok;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CNTW'(DEPTH));
    assign pop_ok  = pop_i && !empty_o;
    assign push_ok = push_i && (!full_o || pop_ok);

    always_comb begin
        d = q;
        if (clr_i) begin
            d.rd  = '0;
            d.wr  = '0;
            d.cnt = '0;
        end else begin
            if (push_ok) begin
                d.mem[q.wr] = wdata_i;
                d.wr        = ptr_next(q.wr);
            end
            if (pop_ok) begin
                d.rd = ptr_next(q.rd);
            end
            case ({push_ok, pop_ok})
                2'b10:   d.cnt = q.cnt + CNTW'(1);
                2'b01:   d.cnt = q.cnt - CNTW'(1);
                default: d.cnt = q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_o = empty_o ? '0 : q.mem[q.rd];

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNTW'(DEPTH));

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (!full_o || pop_i));

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i && !clr_i) |=> empty_o);
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
    import srx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       port_en,
    input  logic       rx_en,
    input  logic       nine_bit,
    input  logic       addr_filt_en,
    input  logic       os_tick,
    input  logic       rx_in,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       rd_ferr,
    output logic       data_avail,
    output logic       overrun,
    output logic       rx_idle
);
    typedef struct packed {
        logic ovr;
    } top_t;

    top_t      d, q;
    logic      clr, hold, rx_s, rx_fall, done, accept, ovr_set, push;
    logic      full, empty;
    srx_char_t rx_char, head;

    assign clr  = ~port_en;
    assign hold = ~rx_en | q.ovr;

    srx_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .rx_i   (rx_in),
        .rx_o   (rx_s),
        .fall_o (rx_fall)
    );

    srx_deframer #(.OSR(OSR)) dfr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .hold_i     (hold),
        .tick_i     (os_tick),
        .rx_i       (rx_s),
        .fall_i     (rx_fall),
        .nine_bit_i (nine_bit),
        .idle_o     (rx_idle),
        .done_o     (done),
        .char_o     (rx_char)
    );

    assign accept  = done && !(addr_filt_en && nine_bit && !rx_char.bit9);
    assign ovr_set = accept && full && !rd_en;
    assign push    = accept && !ovr_set;

    srx_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .push_i  (push),
        .wdata_i (rx_char),
        .pop_i   (rd_en),
        .head_o  (head),
        .full_o  (full),
        .empty_o (empty)
    );

    always_comb begin
        d = q;
        if (clr || !rx_en) begin
            d.ovr = 1'b0;
        end else if (ovr_set) begin
            d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign rd_data    = head.data;
    assign rd_bit9    = head.bit9;
    assign rd_ferr    = head.ferr;
    assign data_avail = ~empty;
    assign overrun    = q.ovr;

    // R4
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && rx_en && port_en) |=> overrun);

    // R10
    port_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> (!data_avail && !overrun));

    // R8
    filt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && addr_filt_en && nine_bit && !rx_char.bit9) |-> (!push && !ovr_set));
endmodule

// File: tb/serial_rx_unit_tb_top.sv
module serial_rx_unit_tb_top;
    localparam int BIT   = 32;
    localparam int DEPTH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_en = 1'b1;
    logic       rx_en = 1'b1;
    logic       nine_bit = 1'b0;
    logic       addr_filt_en = 1'b0;
    logic       os_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, rd_ferr, data_avail, overrun, rx_idle;

    int checks = 0;
    int errors = 0;
    logic [9:0] mq[$];
    bit mo = 1'b0;

    always #2 clk = ~clk;

    serial_rx_unit dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .rx_en(rx_en),
        .nine_bit(nine_bit), .addr_filt_en(addr_filt_en), .os_tick(os_tick),
        .rx_in(rx_in), .rd_en(rd_en), .rd_data(rd_data), .rd_bit9(rd_bit9),
        .rd_ferr(rd_ferr), .data_avail(data_avail), .overrun(overrun),
        .rx_idle(rx_idle)
    );

    initial begin
        forever begin
            @(negedge clk);
            os_tick = ~os_tick;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model_frame(input logic [7:0] dat, input bit b9,
                                        input bit bad);
        bit keep;
        keep = !(addr_filt_en && nine_bit && !b9);
        if (!keep || mo) return;
        if (mq.size() == DEPTH) mo = 1'b1;
        else mq.push_back({bad, nine_bit & b9, dat});
    endfunction

    task automatic send_frame(input logic [7:0] dat, input bit b9, input bit bad,
                              input bit busy);
        rx_in = 1'b0;
        repeat (BIT) @(negedge clk);
        chk(rx_idle == !busy, "R7 idle during frame", rx_idle, !busy);
        for (int i = 0; i < 8; i++) begin
            rx_in = dat[i];
            repeat (BIT) @(negedge clk);
        end
        if (nine_bit) begin
            rx_in = b9;
            repeat (BIT) @(negedge clk);
        end
        rx_in = !bad;
        repeat (BIT) @(negedge clk);
        rx_in = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    task automatic frame_chk(input logic [7:0] dat, input bit b9, input bit bad);
        send_frame(dat, b9, bad, rx_en && !mo);
        if (rx_en) model_frame(dat, b9, bad);
        chk(data_avail == (mq.size() != 0), "R6 data_avail", data_avail, mq.size() != 0);
        chk(overrun == mo, "R4 overrun", overrun, mo);
        chk(rx_idle == 1'b1, "R7 idle after frame", rx_idle, 1);
    endtask

    task automatic pop_chk();
        logic [9:0] e;
        if (mq.size() != 0) begin
            e = mq[0];
            chk(rd_data == e[7:0], "R1 data", rd_data, e[7:0]);
            chk(rd_bit9 == e[8], "R2 ninth bit", rd_bit9, e[8]);
            chk(rd_ferr == e[9], "R5 framing flag", rd_ferr, e[9]);
            void'(mq.pop_front());
        end else begin
            chk({rd_data, rd_bit9, rd_ferr} == 10'd0, "R3 empty head", {rd_data, rd_bit9, rd_ferr}, 0);
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
        chk(data_avail == (mq.size() != 0), "R3 after read", data_avail, mq.size() != 0);
    endtask

    task automatic toggle_rx_en();
        rx_en = 1'b0;
        repeat (3) @(negedge clk);
        rx_en = 1'b1;
        mo = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R4 clear by rx_en", overrun, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5a_0c3b));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk({data_avail, overrun, rx_idle} == 3'b001, "R6 reset state", {data_avail, overrun, rx_idle}, 3'b001);
        chk(rd_data == 8'h00, "R3 reset head", rd_data, 0);

        // R3: read on empty queue is ignored
        pop_chk();
        frame_chk(8'hA5, 1'b0, 1'b0);
        pop_chk();

        // R9: short low glitch
        rx_in = 1'b0;
        repeat (8) @(negedge clk);
        rx_in = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        chk(data_avail == 1'b0, "R9 glitch stores nothing", data_avail, 0);
        chk(rx_idle == 1'b1, "R9 back to idle", rx_idle, 1);

        // R5: bad stop followed directly by a good character
        frame_chk(8'h3C, 1'b0, 1'b1);
        frame_chk(8'hC3, 1'b0, 1'b0);
        pop_chk();
        pop_chk();

        // R4: third character while full, then blocked
        frame_chk(8'h11, 1'b0, 1'b0);
        frame_chk(8'h22, 1'b0, 1'b0);
        frame_chk(8'h33, 1'b0, 1'b0);
        frame_chk(8'h44, 1'b0, 1'b0);
        pop_chk();
        frame_chk(8'h55, 1'b0, 1'b0);
        chk(data_avail == 1'b1, "R4 blocked while overrun", data_avail, 1);
        toggle_rx_en();
        frame_chk(8'h66, 1'b0, 1'b0);
        pop_chk();
        pop_chk();

        // R11: receive enable low
        rx_en = 1'b0;
        send_frame(8'h77, 1'b0, 1'b0, 1'b0);
        chk(data_avail == 1'b0, "R11 disabled receive", data_avail, 0);
        rx_en = 1'b1;

        // R8 and R2: address filter in 9-bit mode
        nine_bit = 1'b1;
        addr_filt_en = 1'b1;
        frame_chk(8'h81, 1'b0, 1'b0);
        chk(data_avail == 1'b0, "R8 filtered", data_avail, 0);
        frame_chk(8'h82, 1'b1, 1'b0);
        pop_chk();
        addr_filt_en = 1'b0;
        frame_chk(8'h83, 1'b0, 1'b0);
        pop_chk();

        // R10: port disable with full queue and overrun
        nine_bit = 1'b0;
        frame_chk(8'h01, 1'b0, 1'b0);
        frame_chk(8'h02, 1'b0, 1'b0);
        frame_chk(8'h03, 1'b0, 1'b0);
        port_en = 1'b0;
        repeat (2) @(negedge clk);
        port_en = 1'b1;
        mq.delete();
        mo = 1'b0;
        @(negedge clk);
        chk({data_avail, overrun, rd_data} == 10'd0, "R10 port clear", {data_avail, overrun, rd_data}, 0);

        // random phase
        for (int n = 0; n < 140; n++) begin
            logic [7:0] dat;
            bit b9, bad;
            if (n % 20 == 0) begin
                nine_bit = $urandom_range(0, 1);
                addr_filt_en = nine_bit && ($urandom_range(0, 1) == 1);
            end
            dat = 8'($urandom);
            b9 = $urandom_range(0, 1);
            bad = ($urandom_range(0, 7) == 0);
            frame_chk(dat, b9, bad);
            for (int k = $urandom_range(0, 2); k > 0; k--) pop_chk();
            if (mo && ($urandom_range(0, 2) == 0)) toggle_rx_en();
        end
        while (mq.size() != 0) pop_chk();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule